// File: doc/BRIEF.md
# Register-Resident Transmit/Receive Descriptor Ring

This block is the descriptor engine of a simple Ethernet MAC. The descriptors are not fetched from memory. Each direction owns four hardware descriptor slots. Each slot holds a buffer address, two control bits and a status word. Software uses a small host register port to arm slots, to poll their done flags and to acknowledge them.

A frame-side handshake stands in for the MAC datapath. On the transmit side, the engine presents the buffer address and length of the armed slot at the current ring position. The MAC answers with a completion pulse that carries its status flags. On the receive side, the engine presents the armed slot's buffer. The MAC answers with a completion pulse that carries the frame length and the receive flags. Completion hands the slot back to software, records the status, sets the done flag and advances the ring position by one, modulo four.

A single level interrupt reports that at least one done flag is pending in either ring. A MAC reset input drops every slot back to software ownership. It does not disturb the ring positions, which software recovers from slot 0 of each ring.

Top module: `desc_ring_engine`

## Requirements
- R1: The host address is {dir, slot[1:0], sel[1:0]}, where dir 0 is transmit and dir 1 is receive. sel 0 is the buffer word, sel 1 is the status word and sel 2 is the transmit length. The buffer word holds the address in bits [31:4], the arm bit in bit 0 and the done bit in bit 1. Reads are combinational.
- R2: A buffer-word write with bit 0 set arms the slot. When the armed slot is at the current position, the valid output of that direction rises and the address output shows the buffer address with bits [3:0] at zero.
- R3: While a slot is armed, host writes to its buffer word and to its length register are ignored.
- R4: A completion pulse on an armed current slot clears the arm bit, sets the done bit and stores the status word. The transmit status has the length in bits [13:0] and the flags in bits [28:24]. The receive status has the length, including the FCS, in bits [13:0] and the flags in bits [31:24].
- R5: The ring position advances by one, modulo 4, on each completion and wraps from 3 to 0. The frame side waits at an unarmed current slot even when later slots are armed.
- R6: Bits [3:2] of the slot-0 buffer word read back that direction's current ring position. The same bits read 0 for the other slots.
- R7: A buffer-word write with bit 1 at 0 to an unarmed slot clears its done bit. The same write with bit 1 at 1 leaves the done bit unchanged.
- R8: irq_o is high while any done bit in either ring is set, and low once all of them are cleared.
- R9: A mac_clr_i pulse clears the arm and done bits of all eight slots. It keeps the buffer addresses and both ring positions.
- R10: A transmit length below 60 is reported as 60, both on tx_len_o and in the status word. Lengths of 60 or more are reported unchanged.
- R11: A completion pulse while the current slot is unarmed is ignored. The position, status and slots stay unchanged.
- R12: After rst_ni, all slots are unarmed and not done, both positions are 0, and irq_o, tx_valid_o and rx_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mac_clr_i | input | 1 | MAC reset: drop all slots to software ownership |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 5 | Host register address {dir, slot, sel} |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data |
| tx_valid_o | output | 1 | Current transmit slot is armed |
| tx_addr_o | output | 32 | Buffer address of the current transmit slot |
| tx_len_o | output | 14 | Padded length of the current transmit slot |
| tx_fin_i | input | 1 | Transmit completion pulse |
| tx_flags_i | input | 5 | Transmit status flags |
| rx_valid_o | output | 1 | Current receive slot is armed |
| rx_addr_o | output | 32 | Buffer address of the current receive slot |
| rx_fin_i | input | 1 | Receive completion pulse |
| rx_len_i | input | 14 | Received frame length, including the FCS |
| rx_flags_i | input | 8 | Receive status flags |
| irq_o | output | 1 | Any done bit pending |

## Verification
The transmit ring is first driven with slots armed in order. It is then driven with a gap, where slot 2 is armed while slot 1 is not, so the bench can tell strict ring-order service from "any armed slot" service. Completion pulses are sent while the current slot is empty, and writes are aimed at slots the MAC owns; these checks separate the ownership gating from plain register behaviour. A full wrap of four completions, short and long transmit lengths, and a mixed receive/MAC-reset sequence show that the ring position survives a MAC reset while the arm and done bits do not.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  typedef enum logic [1:0] {
    SEL_BUF  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int ARM_BIT  = 0;
  localparam int DONE_BIT = 1;
  localparam int FLAG_LSB = 24;
endpackage

// File: rtl/desc_slot.sv
module desc_slot #(
  parameter int DW      = 32,
  parameter int LEN_W   = 14,
  parameter bit HAS_LEN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_buf_i,
  input  logic             wr_len_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             fin_i,
  input  logic [DW-1:0]    fin_stat_i,
  output logic [DW-5:0]    addr_o,
  output logic             en_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o,
  output logic [DW-1:0]    stat_o
);
  import desc_ring_pkg::*;

  logic [DW-5:0] addr_q;
  logic          en_q, done_q;
  logic [DW-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      stat_q <= '0;
    end else if (clr_i) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (fin_i) begin
      en_q   <= 1'b0;
      done_q <= 1'b1;
      stat_q <= fin_stat_i;
    end else if (wr_buf_i && !en_q) begin
      addr_q <= wdata_i[DW-1:4];
      en_q   <= wdata_i[ARM_BIT];
      done_q <= done_q & wdata_i[DONE_BIT];
    end
  end

  generate
    if (HAS_LEN) begin : g_len
      logic [LEN_W-1:0] len_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                len_q <= '0;
        else if (wr_len_i && !en_q) len_q <= wdata_i[LEN_W-1:0];
      end
      assign len_o = len_q;
    end else begin : g_nolen
      assign len_o = '0;
    end
  endgenerate

  assign addr_o = addr_q;
  assign en_o   = en_q;
  assign done_o = done_q;
  assign stat_o = stat_q;

  assert_armed_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_buf_i && en_o && !clr_i && !fin_i) |=> $stable(addr_o));
  assert_fin_sets_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !clr_i) |=> (done_o && !en_o));
  assert_clr_drops_ctl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!en_o && !done_o));
endmodule

// File: rtl/desc_dir.sv
module desc_dir #(
  parameter int N       = 4,
  parameter int DW      = 32,
  parameter int LEN_W   = 14,
  parameter bit HAS_LEN = 1'b1,
  localparam int IW     = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_en_i,
  input  logic [IW-1:0]         slot_i,
  input  desc_ring_pkg::reg_sel_e sel_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  valid_o,
  output logic [DW-1:0]         addr_o,
  output logic [LEN_W-1:0]      len_o,
  input  logic                  fin_i,
  input  logic [DW-1:0]         fin_stat_i,
  output logic                  done_any_o
);
  import desc_ring_pkg::*;

  logic [IW-1:0]    idx_q;
  logic             adv;
  logic [N-1:0]     en_a, done_a;
  logic [DW-5:0]    addr_a [N];
  logic [LEN_W-1:0] len_a  [N];
  logic [DW-1:0]    stat_a [N];

  assign adv = fin_i && en_a[idx_q] && !clr_i;

  for (genvar i = 0; i < N; i++) begin : g_slot
    desc_slot #(.DW(DW), .LEN_W(LEN_W), .HAS_LEN(HAS_LEN)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .wr_buf_i   (wr_en_i && slot_i == IW'(i) && sel_i == SEL_BUF),
      .wr_len_i   (wr_en_i && slot_i == IW'(i) && sel_i == SEL_LEN),
      .wdata_i    (wdata_i),
      .fin_i      (adv && idx_q == IW'(i)),
      .fin_stat_i (fin_stat_i),
      .addr_o     (addr_a[i]),
      .en_o       (en_a[i]),
      .done_o     (done_a[i]),
      .len_o      (len_a[i]),
      .stat_o     (stat_a[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  idx_q <= '0;
    else if (adv) idx_q <= (idx_q == IW'(N-1)) ? '0 : idx_q + 1'b1;
  end

  logic [1:0] pos_field;
  assign pos_field = (slot_i == '0) ? 2'(idx_q) : 2'b00;

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_BUF:  rdata_o = {addr_a[slot_i], pos_field, done_a[slot_i], en_a[slot_i]};
      SEL_STAT: rdata_o = stat_a[slot_i];
      SEL_LEN:  rdata_o = DW'(len_a[slot_i]);
      default:  rdata_o = '0;
    endcase
  end

  assign valid_o    = en_a[idx_q];
  assign addr_o     = {addr_a[idx_q], 4'b0000};
  assign len_o      = len_a[idx_q];
  assign done_any_o = |done_a;

  assert_index_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> (32'(idx_q) == (32'($past(idx_q)) + 1) % N));
  assert_index_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(idx_q));
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine #(
  parameter int N       = 4,
  parameter int DW      = 32,
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 60,
  localparam int IW     = $clog2(N),
  localparam int HA_W   = 1 + IW + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mac_clr_i,
  input  logic             host_we_i,
  input  logic [HA_W-1:0]  host_addr_i,
  input  logic [DW-1:0]    host_wdata_i,
  output logic [DW-1:0]    host_rdata_o,
  output logic             tx_valid_o,
  output logic [DW-1:0]    tx_addr_o,
  output logic [LEN_W-1:0] tx_len_o,
  input  logic             tx_fin_i,
  input  logic [4:0]       tx_flags_i,
  output logic             rx_valid_o,
  output logic [DW-1:0]    rx_addr_o,
  input  logic             rx_fin_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic [7:0]       rx_flags_i,
  output logic             irq_o
);
  import desc_ring_pkg::*;

  logic                 dir_rx;
  logic [IW-1:0]        slot;
  reg_sel_e             sel;
  logic [DW-1:0]        tx_rdata, rx_rdata, tx_stat, rx_stat;
  logic [LEN_W-1:0]     tx_len_raw, rx_len_unused;
  logic                 tx_done_any, rx_done_any;

  assign dir_rx = host_addr_i[HA_W-1];
  assign slot   = host_addr_i[IW+1:2];
  assign sel    = reg_sel_e'(host_addr_i[1:0]);

  assign tx_len_o = (tx_len_raw < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : tx_len_raw;

  always_comb begin
    tx_stat = '0;
    tx_stat[LEN_W-1:0] = tx_len_o;
    tx_stat[FLAG_LSB +: 5] = tx_flags_i;
    rx_stat = '0;
    rx_stat[LEN_W-1:0] = rx_len_i;
    rx_stat[FLAG_LSB +: 8] = rx_flags_i;
  end

  desc_dir #(.N(N), .DW(DW), .LEN_W(LEN_W), .HAS_LEN(1'b1)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (mac_clr_i),
    .wr_en_i    (host_we_i && !dir_rx),
    .slot_i     (slot),
    .sel_i      (sel),
    .wdata_i    (host_wdata_i),
    .rdata_o    (tx_rdata),
    .valid_o    (tx_valid_o),
    .addr_o     (tx_addr_o),
    .len_o      (tx_len_raw),
    .fin_i      (tx_fin_i),
    .fin_stat_i (tx_stat),
    .done_any_o (tx_done_any)
  );

  desc_dir #(.N(N), .DW(DW), .LEN_W(LEN_W), .HAS_LEN(1'b0)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (mac_clr_i),
    .wr_en_i    (host_we_i && dir_rx),
    .slot_i     (slot),
    .sel_i      (sel),
    .wdata_i    (host_wdata_i),
    .rdata_o    (rx_rdata),
    .valid_o    (rx_valid_o),
    .addr_o     (rx_addr_o),
    .len_o      (rx_len_unused),
    .fin_i      (rx_fin_i),
    .fin_stat_i (rx_stat),
    .done_any_o (rx_done_any)
  );

  assign host_rdata_o = dir_rx ? rx_rdata : tx_rdata;
  assign irq_o        = tx_done_any | rx_done_any;

  assert_irq_drops_on_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_clr_i |=> !irq_o);
  assert_tx_len_floor_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_len_o >= LEN_W'(MIN_LEN)));
  assert_irq_on_fin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_fin_i && tx_valid_o && !mac_clr_i) |=> irq_o);
endmodule

// File: tb/desc_ring_engine_bench.sv
module desc_ring_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mac_clr = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_valid, rx_valid, irq;
  logic [31:0] tx_addr, rx_addr;
  logic [13:0] tx_len;
  logic        tx_fin = 1'b0, rx_fin = 1'b0;
  logic [4:0]  tx_flags = '0;
  logic [13:0] rx_len = '0;
  logic [7:0]  rx_flags = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_engine u_desc_ring_engine (
    .clk_i(clk), .rst_ni(rst_ni), .mac_clr_i(mac_clr),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .tx_valid_o(tx_valid), .tx_addr_o(tx_addr), .tx_len_o(tx_len),
    .tx_fin_i(tx_fin), .tx_flags_i(tx_flags),
    .rx_valid_o(rx_valid), .rx_addr_o(rx_addr),
    .rx_fin_i(rx_fin), .rx_len_i(rx_len), .rx_flags_i(rx_flags),
    .irq_o(irq)
  );

  function automatic logic [4:0] ta(input int dir, input int s, input int sel);
    return 5'((dir << 4) | (s << 2) | sel);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic tx_done(input logic [4:0] f);
    @(negedge clk);
    tx_fin = 1'b1; tx_flags = f;
    @(negedge clk);
    tx_fin = 1'b0;
  endtask

  task automatic rx_done(input logic [13:0] l, input logic [7:0] f);
    @(negedge clk);
    rx_fin = 1'b1; rx_len = l; rx_flags = f;
    @(negedge clk);
    rx_fin = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(ta(0,0,0), d); chk("R12 tx slot0 word", d, 32'h0);
    rd(ta(1,0,0), d); chk("R12 rx slot0 word", d, 32'h0);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 tx_valid", 32'(tx_valid), 0);
    chk("R12 rx_valid", 32'(rx_valid), 0);
  endtask

  task automatic t_arm_and_busy;
    logic [31:0] d;
    wr(ta(0,0,2), 32'd40);
    wr(ta(0,0,0), 32'h0000_1001);
    rd(ta(0,0,0), d); chk("R1 tx slot0 readback", d, 32'h0000_1001);
    chk("R2 tx_valid armed", 32'(tx_valid), 1);
    chk("R2 tx_addr", tx_addr, 32'h0000_1000);
    chk("R10 short length padded", 32'(tx_len), 60);
    wr(ta(0,0,0), 32'h0000_2000);
    rd(ta(0,0,0), d); chk("R3 armed buffer write ignored", d, 32'h0000_1001);
    wr(ta(0,0,2), 32'd100);
    rd(ta(0,0,2), d); chk("R3 armed length write ignored", d, 32'd40);
    chk("R3 tx_len unchanged", 32'(tx_len), 60);
  endtask

  task automatic t_tx_complete;
    logic [31:0] d;
    tx_done(5'b10010);
    rd(ta(0,0,0), d); chk("R4 R6 slot0 done, pos 1", d, 32'h0000_1006);
    rd(ta(0,0,1), d); chk("R4 R10 tx status", d, 32'h1200_003C);
    chk("R8 irq after done", 32'(irq), 1);
    chk("R5 no armed slot at pos 1", 32'(tx_valid), 0);
  endtask

  task automatic t_order_and_wrap;
    logic [31:0] d;
    wr(ta(0,2,0), 32'h0000_3001);
    chk("R5 waits at unarmed slot1", 32'(tx_valid), 0);
    tx_done(5'b00001);
    rd(ta(0,0,0), d); chk("R11 stray fin keeps pos", d, 32'h0000_1006);
    rd(ta(0,2,0), d); chk("R11 stray fin keeps slot2", d, 32'h0000_3001);
    rd(ta(0,2,1), d); chk("R11 stray fin no status", d, 32'h0);
    rd(ta(0,1,0), d); chk("R6 pos bits zero on slot1", d, 32'h0);
    wr(ta(0,1,2), 32'd200);
    wr(ta(0,1,0), 32'h0000_2001);
    chk("R2 slot1 addr", tx_addr, 32'h0000_2000);
    chk("R10 long length unchanged", 32'(tx_len), 200);
    tx_done(5'b00000);
    rd(ta(0,1,1), d); chk("R4 slot1 status", d, 32'h0000_00C8);
    chk("R5 advances to slot2", tx_addr, 32'h0000_3000);
    chk("R5 slot2 valid", 32'(tx_valid), 1);
    tx_done(5'b00000);
    wr(ta(0,3,0), 32'h0000_6001);
    tx_done(5'b00100);
    rd(ta(0,3,1), d); chk("R4 slot3 status", d, 32'h0400_003C);
    rd(ta(0,0,0), d); chk("R5 wrap to pos 0", d, 32'h0000_1002);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    wr(ta(0,0,0), 32'h0000_1002);
    rd(ta(0,0,0), d); chk("R7 done kept with bit1 set", d, 32'h0000_1002);
    wr(ta(0,0,0), 32'h0000_1000);
    rd(ta(0,0,0), d); chk("R7 done cleared", d, 32'h0000_1000);
    chk("R8 irq held by other slots", 32'(irq), 1);
    wr(ta(0,1,0), 32'h0000_2000);
    wr(ta(0,2,0), 32'h0000_3000);
    wr(ta(0,3,0), 32'h0000_6000);
    chk("R8 irq low when all cleared", 32'(irq), 0);
  endtask

  task automatic t_rx_and_clr;
    logic [31:0] d;
    wr(ta(1,0,0), 32'h0000_4001);
    wr(ta(1,1,0), 32'h0000_5001);
    chk("R2 rx_valid", 32'(rx_valid), 1);
    chk("R2 rx_addr", rx_addr, 32'h0000_4000);
    rx_done(14'd64, 8'h03);
    rd(ta(1,0,1), d); chk("R4 rx status", d, 32'h0300_0040);
    rd(ta(1,0,0), d); chk("R6 rx pos 1", d, 32'h0000_4006);
    chk("R5 rx next slot", rx_addr, 32'h0000_5000);
    rd(ta(0,0,0), d); chk("R6 tx pos unaffected", d, 32'h0000_1000);
    chk("R8 irq from rx", 32'(irq), 1);
    @(negedge clk); mac_clr = 1'b1;
    @(negedge clk); mac_clr = 1'b0;
    rd(ta(1,0,0), d); chk("R9 rx slot0 cleared, pos kept", d, 32'h0000_4004);
    rd(ta(1,1,0), d); chk("R9 rx slot1 disarmed", d, 32'h0000_5000);
    chk("R9 irq low", 32'(irq), 0);
    chk("R9 rx_valid low", 32'(rx_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm_and_busy();
    t_tx_complete();
    t_order_and_wrap();
    t_ack();
    t_rx_and_clr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule